// File: doc/BRIEF.md
# Comparator Blanking and Edge Interrupt

This block sits behind an analog comparator whose threshold is set by a DAC. Each time the DAC output is stepped, the comparator may toggle briefly while the analog node settles, so the block hides the comparator for a programmable number of clock cycles after every DAC step. Outside that window it reports the comparator level and can raise a one-cycle interrupt on a rising edge, a falling edge, both, or neither.

The raw comparator bit passes through a two-flop synchronizer before anything else looks at it. A DAC-change pulse loads a down-counter with the 10-bit blanking length. While the counter is non-zero the output holds its last accepted value. When the window closes, the output takes the comparator level that is current at that point, and this catch-up step is never reported as an edge. Clearing the module enable drops any blanking in progress and keeps the interrupt low.

Every port is a plain control or status pin: nothing streams through the block, so there is no valid/ready handshake and no back-pressure to honour. The interrupt is a level that is high for exactly one clock and is not held until acknowledged.

Top module: `cmp_blank_irq`

## Requirements
- R1: With the module enabled and no blanking active, a change on `cmp_raw` that is set up before rising edge k appears on `cmp_blanked` after rising edge k+2, and not earlier.
- R2: A `dac_change` pulse sampled at rising edge d with `enable` high and `blank_len` = N (N from 1 to 1023) keeps `cmp_blanked` constant through rising edge d+N.
- R3: After a blanking window ends, `cmp_blanked` takes the synchronized comparator level at the next rising edge, and no interrupt is raised for any change or glitch that happened inside the window.
- R4: A `dac_change` pulse that arrives while a window is running restarts the window with the full `blank_len`.
- R5: A `blank_len` of zero gives no blanking, so edges right after a DAC change are reported.
- R6: `irq_mode` = 00 never raises `irq_pulse`.
- R7: `irq_mode` = 01 raises `irq_pulse` when `cmp_blanked` goes from 0 to 1, and only then.
- R8: `irq_mode` = 10 raises `irq_pulse` when `cmp_blanked` goes from 1 to 0, and only then.
- R9: `irq_mode` = 11 raises `irq_pulse` on either transition of `cmp_blanked`.
- R10: Each reported edge makes `irq_pulse` high for exactly one clock cycle, in the same cycle that `cmp_blanked` takes its new value.
- R11: While `enable` is low, `irq_pulse` stays low, any running blanking window is cancelled, and `cmp_blanked` follows the synchronized comparator.
- R12: During and right after reset, `cmp_blanked` and `irq_pulse` are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Module enable. Low cancels blanking and silences the interrupt |
| blank_len | input | 10 | Blanking length in clock cycles. Zero means no blanking |
| irq_mode | input | 2 | 00 off, 01 rising, 10 falling, 11 both |
| dac_change | input | 1 | One-cycle pulse marking a DAC output step |
| cmp_raw | input | 1 | Asynchronous comparator result |
| cmp_blanked | output | 1 | Synchronized comparator level with blanking applied |
| irq_pulse | output | 1 | One-cycle edge interrupt |

## Verification
All four mode codes are driven with the same rise-then-fall comparator step, so that a mode reacting to the wrong direction, or to both directions when it should not, shows up as a wrong pulse count. A step placed inside a window, and a short glitch placed inside a window, separate a window that truly masks from one that only delays. A second DAC pulse placed late in a window tells a full restart apart from a window that keeps its original end. A zero length, and a disable in the middle of a window, show whether the cancel and bypass paths really remove blanking.

// File: rtl/cbi_pkg.sv
package cbi_pkg;
  typedef enum logic [1:0] {
    IRQ_OFF  = 2'b00,
    IRQ_RISE = 2'b01,
    IRQ_FALL = 2'b10,
    IRQ_BOTH = 2'b11
  } irq_mode_e;

  localparam int unsigned BLANK_W_DEF  = 10;
  localparam int unsigned SYNC_STG_DEF = 2;
endpackage

// File: rtl/cbi_sync.sv
module cbi_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cbi_blank_timer.sv
module cbi_blank_timer #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             restart,
  input  logic [CNT_W-1:0] length,
  output logic             blank,
  output logic             was_blank
);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain    <= '0;
      was_blank <= 1'b0;
    end else if (!enable) begin
      remain    <= '0;
      was_blank <= 1'b0;
    end else begin
      was_blank <= blank;
      if (restart)
        remain <= length;
      else if (remain != '0)
        remain <= remain - 1'b1;
    end
  end

  assign blank = (remain != '0);
endmodule

// File: rtl/cbi_edge_irq.sv
module cbi_edge_irq
  import cbi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic [1:0] mode,
  input  logic       cmp_in,
  input  logic       blank,
  input  logic       was_blank,
  output logic       cmp_out,
  output logic       irq
);
  irq_mode_e sel;
  logic      take, differs, hit, report;

  always_comb begin
    sel     = irq_mode_e'(mode);
    take    = enable && !blank;
    differs = (cmp_in != cmp_out);
    unique case (sel)
      IRQ_RISE: hit = differs && cmp_in;
      IRQ_FALL: hit = differs && !cmp_in;
      IRQ_BOTH: hit = differs;
      default:  hit = 1'b0;
    endcase
    // the first open cycle after a window only catches up, silently
    report = take && !was_blank && hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_out <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (!enable || take)
        cmp_out <= cmp_in;
      irq <= report;
    end
  end
endmodule

// File: rtl/cmp_blank_irq.sv
module cmp_blank_irq #(
  parameter int unsigned BLANK_W  = cbi_pkg::BLANK_W_DEF,
  parameter int unsigned SYNC_STG = cbi_pkg::SYNC_STG_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [BLANK_W-1:0] blank_len,
  input  logic [1:0]         irq_mode,
  input  logic               dac_change,
  input  logic               cmp_raw,
  output logic               cmp_blanked,
  output logic               irq_pulse
);
  logic cmp_sync;
  logic blank, was_blank;

  cbi_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (cmp_raw),
    .q     (cmp_sync)
  );

  cbi_blank_timer #(.CNT_W(BLANK_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .restart   (dac_change),
    .length    (blank_len),
    .blank     (blank),
    .was_blank (was_blank)
  );

  cbi_edge_irq u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .mode      (irq_mode),
    .cmp_in    (cmp_sync),
    .blank     (blank),
    .was_blank (was_blank),
    .cmp_out   (cmp_blanked),
    .irq       (irq_pulse)
  );
endmodule

// File: rtl/cmp_blank_irq_checker.sv
module cmp_blank_irq_checker #(
  parameter int unsigned BLANK_W = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               enable,
  input logic [BLANK_W-1:0] blank_len,
  input logic [1:0]         irq_mode,
  input logic               dac_change,
  input logic               cmp_blanked,
  input logic               irq_pulse
);
  a_r10_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);

  a_r10_irq_with_change: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> (cmp_blanked != $past(cmp_blanked)));

  a_r11_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !irq_pulse);

  a_r6_mode_off: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mode == 2'b00) |=> !irq_pulse);

  a_r7_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mode == 2'b01) |=> (!irq_pulse || cmp_blanked));

  a_r8_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mode == 2'b10) |=> (!irq_pulse || !cmp_blanked));

  a_r2_hold_after_step: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && dac_change && blank_len != '0) |=> ##1 $stable(cmp_blanked));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_r12_reset_low: assert (!irq_pulse);
    end
  end
endmodule

bind cmp_blank_irq cmp_blank_irq_checker #(.BLANK_W(BLANK_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .blank_len   (blank_len),
  .irq_mode    (irq_mode),
  .dac_change  (dac_change),
  .cmp_blanked (cmp_blanked),
  .irq_pulse   (irq_pulse)
);

// File: tb/cmp_blank_irq_tb_top.sv
module cmp_blank_irq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       enable;
  logic [9:0] blank_len;
  logic [1:0] irq_mode;
  logic       dac_change;
  logic       cmp_raw;
  logic       cmp_blanked;
  logic       irq_pulse;

  int checks = 0;
  int failures = 0;
  int irq_cnt = 0;
  int cyc = 0;
  bit done = 1'b0;
  int base;

  always #2 clk = ~clk;

  cmp_blank_irq dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .blank_len   (blank_len),
    .irq_mode    (irq_mode),
    .dac_change  (dac_change),
    .cmp_raw     (cmp_raw),
    .cmp_blanked (cmp_blanked),
    .irq_pulse   (irq_pulse)
  );

  // counts cycles with the interrupt high
  always @(posedge clk) begin
    irq_cnt <= irq_cnt + int'(irq_pulse);
    cyc     <= cyc + 1;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog: run hung, actual=%0d expected<=20000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_dac();
    dac_change = 1'b1;
    step(1);
    dac_change = 1'b0;
  endtask

  // {mode, rise pulses, fall pulses}: R6 R7 R8 R9 with R10 single cycle
  localparam logic [5:0] VEC [4] = '{
    {2'b00, 2'd0, 2'd0},
    {2'b01, 2'd1, 2'd0},
    {2'b10, 2'd0, 2'd1},
    {2'b11, 2'd1, 2'd1}
  };

  initial begin
    rst_n = 1'b0; enable = 1'b1; blank_len = '0; irq_mode = 2'b00;
    dac_change = 1'b0; cmp_raw = 1'b0;
    step(3);
    check(cmp_blanked == 1'b0, "R12 out in reset", int'(cmp_blanked), 0);
    check(irq_pulse == 1'b0, "R12 irq in reset", int'(irq_pulse), 0);
    rst_n = 1'b1;
    step(2);
    check(cmp_blanked == 1'b0 && irq_pulse == 1'b0, "R12 after reset",
          int'({cmp_blanked, irq_pulse}), 0);

    for (int i = 0; i < 4; i++) begin
      irq_mode = VEC[i][5:4];
      cmp_raw = 1'b0;
      step(5);
      base = irq_cnt;
      cmp_raw = 1'b1;
      step(6);
      check(irq_cnt - base == int'(VEC[i][3:2]), "R6/R7/R8/R9/R10 rise count",
            irq_cnt - base, int'(VEC[i][3:2]));
      base = irq_cnt;
      cmp_raw = 1'b0;
      step(6);
      check(irq_cnt - base == int'(VEC[i][1:0]), "R6/R7/R8/R9/R10 fall count",
            irq_cnt - base, int'(VEC[i][1:0]));
    end

    // R1 latency
    irq_mode = 2'b11;
    step(3);
    cmp_raw = 1'b1;
    step(2);
    check(cmp_blanked == 1'b0, "R1 not before third edge", int'(cmp_blanked), 0);
    step(1);
    check(cmp_blanked == 1'b1, "R1 at third edge", int'(cmp_blanked), 1);
    cmp_raw = 1'b0;
    step(5);

    // R2 window length, R3 silent catch-up
    blank_len = 10'd20;
    base = irq_cnt;
    pulse_dac();
    step(2);
    cmp_raw = 1'b1;
    step(8);
    check(cmp_blanked == 1'b0, "R2 inside window", int'(cmp_blanked), 0);
    step(10);
    check(cmp_blanked == 1'b0, "R2 last blanked edge", int'(cmp_blanked), 0);
    step(1);
    check(cmp_blanked == 1'b1, "R3 catch-up value", int'(cmp_blanked), 1);
    step(4);
    check(irq_cnt - base == 0, "R3 no irq for hidden step", irq_cnt - base, 0);

    // R3 glitch inside the window
    base = irq_cnt;
    pulse_dac();
    step(3);
    cmp_raw = 1'b0;
    step(3);
    cmp_raw = 1'b1;
    step(25);
    check(irq_cnt - base == 0, "R3 no irq for glitch", irq_cnt - base, 0);
    check(cmp_blanked == 1'b1, "R3 level after glitch", int'(cmp_blanked), 1);

    // R4 restart
    blank_len = 10'd10;
    base = irq_cnt;
    pulse_dac();
    step(5);
    pulse_dac();
    step(2);
    cmp_raw = 1'b0;
    step(5);
    check(cmp_blanked == 1'b1, "R4 window extended", int'(cmp_blanked), 1);
    step(4);
    check(cmp_blanked == 1'b0, "R4 after new window", int'(cmp_blanked), 0);
    check(irq_cnt - base == 0, "R4 no irq", irq_cnt - base, 0);
    step(3);

    // R5 zero length
    blank_len = 10'd0;
    irq_mode = 2'b01;
    base = irq_cnt;
    cmp_raw = 1'b1;
    pulse_dac();
    step(2);
    check(cmp_blanked == 1'b1, "R5 no blanking", int'(cmp_blanked), 1);
    step(2);
    check(irq_cnt - base == 1, "R5 edge reported", irq_cnt - base, 1);

    // R11 disabled
    irq_mode = 2'b11;
    enable = 1'b0;
    step(2);
    base = irq_cnt;
    cmp_raw = 1'b0;
    step(3);
    check(cmp_blanked == 1'b0, "R11 output follows", int'(cmp_blanked), 0);
    step(3);
    check(irq_cnt - base == 0, "R11 irq silent", irq_cnt - base, 0);

    // R11 window cancelled by disable
    enable = 1'b1;
    blank_len = 10'd50;
    step(2);
    pulse_dac();
    step(3);
    enable = 1'b0;
    step(1);
    enable = 1'b1;
    base = irq_cnt;
    cmp_raw = 1'b1;
    step(3);
    check(cmp_blanked == 1'b1, "R11 window cleared", int'(cmp_blanked), 1);
    step(2);
    check(irq_cnt - base == 1, "R11 edge after re-enable", irq_cnt - base, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule